// File: doc/BRIEF.md
# Two-Stage Compare-Value Watchdog

This block watches a free-running 64-bit system count that it receives from outside. Software arms it by setting an enable flag and a 32-bit span. Each refresh moves a 64-bit deadline to "count now plus span". When the count passes the deadline, the block raises a warning line, meant to drive an interrupt. In the same cycle it moves the deadline on by the span once more, with no software action. If the count also passes that second deadline before any refresh, a reset request line rises. It stays high until the next refresh.

Software reaches the block through two simple 32-bit register ports. The kick port is used only for refreshes. The setup port holds the control/status word, the span and the two halves of the deadline. Software may also write the deadline directly to set the first watch period. A write to the control/status word or to the span also counts as a refresh. Both ports return a fixed identification word at byte offset 0xFCC. Reads are combinational: `*_rdata` shows the addressed register while the port is selected, and is 0 otherwise.

Top module: `dual_stage_wdog`

## Requirements
- R1: After reset, enable, warning and reset-request are all 0, the span is 0 and the deadline is 0. Both output lines are low.
- R2: A write of any value to kick-port offset 0x000 is a refresh. It clears warning and reset-request. It loads deadline = count + zero-extended span, taken modulo 2^64, using the count present in the write cycle.
- R3: A setup-port write to 0x000 sets enable from data bit 0 and is a refresh. A write to 0x008 stores the 32-bit span and is a refresh that already uses the new span.
- R4: Setup-port offsets 0x010 and 0x014 hold deadline bits 31:0 and 63:32. Each can be written and read alone. These writes are not refreshes.
- R5: While enabled with warning clear, a count strictly greater than the deadline sets warning on the next edge and loads deadline = count + span. A count equal to the deadline does nothing.
- R6: While warning is set, a count strictly greater than the deadline sets reset-request. Reset-request stays set until a refresh.
- R7: While enable is 0, neither warning nor reset-request can assert, whatever the count does.
- R8: A read of setup-port 0x000 returns enable in bit 0, warning in bit 1 and reset-request in bit 2. All other bits read 0.
- R9: Offset 0xFCC on either port reads as the IDENT parameter.
- R10: Any other offset, a read of kick-port 0x000, and any unselected port all read 0. Writes to other offsets change nothing.
- R11: A refresh wins over a deadline-half write in the same cycle. A deadline-half write wins over an expiry in the same cycle, so no expiry is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_count | input | 64 | Free-running system count |
| rf_sel | input | 1 | Kick port select |
| rf_wr | input | 1 | Kick port write strobe |
| rf_addr | input | 12 | Kick port byte offset |
| rf_rdata | output | 32 | Kick port read data |
| cf_sel | input | 1 | Setup port select |
| cf_wr | input | 1 | Setup port write strobe |
| cf_addr | input | 12 | Setup port byte offset |
| cf_wdata | input | 32 | Setup port write data |
| cf_rdata | output | 32 | Setup port read data |
| warn_o | output | 1 | First-stage warning (interrupt) |
| wdog_reset_o | output | 1 | Second-stage reset request |

## Verification
The assertions assume that reset is applied before the first access. They also assume that each port presents at most one access per cycle, with address, strobe and data held steady across the rising edge. The reload check also assumes the span cannot change while warning is set. That holds because every span write is itself a refresh. The bench changes inputs only at the falling edge and issues one access per port per cycle. It lets the count step by one each cycle. It jumps or freezes the count on purpose to reach the equality boundary, the wrap of the 64-bit addition and the disabled case.

// File: rtl/dswd_pkg.sv
package dswd_pkg;
  localparam int unsigned CNT_W  = 64;
  localparam int unsigned SPAN_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned PAD_W  = CNT_W - SPAN_W;

  localparam logic [ADDR_W-1:0] A_KICK  = 12'h000;
  localparam logic [ADDR_W-1:0] A_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] A_SPAN  = 12'h008;
  localparam logic [ADDR_W-1:0] A_DL_LO = 12'h010;
  localparam logic [ADDR_W-1:0] A_DL_HI = 12'h014;
  localparam logic [ADDR_W-1:0] A_IDENT = 12'hFCC;

  typedef struct packed {
    logic ctrl;
    logic span;
    logic dl_lo;
    logic dl_hi;
  } setup_wr_t;

  // Deadline arithmetic: count plus zero-extended span, modulo 2^64.
  function automatic logic [CNT_W-1:0] deadline(input logic [CNT_W-1:0] now,
                                                input logic [SPAN_W-1:0] span);
    return now + {{PAD_W{1'b0}}, span};
  endfunction

  function automatic logic [DATA_W-1:0] status_word(input logic en,
                                                    input logic warn,
                                                    input logic rst_req);
    return {{(DATA_W-3){1'b0}}, rst_req, warn, en};
  endfunction
endpackage

// File: rtl/dswd_regs.sv
module dswd_regs
  import dswd_pkg::*;
#(
  parameter logic [DATA_W-1:0] IDENT = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rf_sel,
  input  logic              rf_wr,
  input  logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_rdata,
  input  logic              cf_sel,
  input  logic              cf_wr,
  input  logic [ADDR_W-1:0] cf_addr,
  input  logic [DATA_W-1:0] cf_wdata,
  output logic [DATA_W-1:0] cf_rdata,
  input  logic [CNT_W-1:0]  dl_i,
  input  logic              warn_i,
  input  logic              rst_req_i,
  output logic              enable_o,
  output logic [SPAN_W-1:0] span_q_o,
  output logic [SPAN_W-1:0] span_now_o,
  output logic              refresh_o,
  output logic              dl_lo_we_o,
  output logic              dl_hi_we_o
);
  setup_wr_t wr;
  logic      kick;
  logic      cf_we;

  assign cf_we    = cf_sel & cf_wr;
  assign wr.ctrl  = cf_we & (cf_addr == A_CTRL);
  assign wr.span  = cf_we & (cf_addr == A_SPAN);
  assign wr.dl_lo = cf_we & (cf_addr == A_DL_LO);
  assign wr.dl_hi = cf_we & (cf_addr == A_DL_HI);
  assign kick     = rf_sel & rf_wr & (rf_addr == A_KICK);

  assign refresh_o  = kick | wr.ctrl | wr.span;
  assign dl_lo_we_o = wr.dl_lo;
  assign dl_hi_we_o = wr.dl_hi;
  assign span_now_o = wr.span ? cf_wdata[SPAN_W-1:0] : span_q_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_o <= 1'b0;
      span_q_o <= '0;
    end else begin
      if (wr.ctrl) enable_o <= cf_wdata[0];
      if (wr.span) span_q_o <= cf_wdata[SPAN_W-1:0];
    end
  end

  always_comb begin
    cf_rdata = '0;
    if (cf_sel) begin
      unique case (cf_addr)
        A_CTRL:  cf_rdata = status_word(enable_o, warn_i, rst_req_i);
        A_SPAN:  cf_rdata = span_q_o;
        A_DL_LO: cf_rdata = dl_i[DATA_W-1:0];
        A_DL_HI: cf_rdata = dl_i[CNT_W-1:DATA_W];
        A_IDENT: cf_rdata = IDENT;
        default: cf_rdata = '0;
      endcase
    end
  end

  assign rf_rdata = (rf_sel && rf_addr == A_IDENT) ? IDENT : '0;

  // R10: decoded setup-port write strobes are mutually exclusive
  assert_onehot_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr.ctrl, wr.span, wr.dl_lo, wr.dl_hi}));
  // R3: a span write is visible on the next read of the span register
  assert_span_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr.span |=> span_q_o == $past(cf_wdata));
endmodule

// File: rtl/dswd_core.sv
module dswd_core
  import dswd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              enable_i,
  input  logic              refresh_i,
  input  logic [SPAN_W-1:0] span_now_i,
  input  logic [SPAN_W-1:0] span_q_i,
  input  logic              dl_lo_we_i,
  input  logic              dl_hi_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  dl_q,
  output logic              warn_q,
  output logic              rst_req_q,
  output logic              expired
);
  logic direct_wr;

  assign expired   = enable_i & (count_i > dl_q);
  assign direct_wr = dl_lo_we_i | dl_hi_we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_q      <= '0;
      warn_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else if (refresh_i) begin
      dl_q      <= deadline(count_i, span_now_i);
      warn_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else if (direct_wr) begin
      if (dl_lo_we_i) dl_q[DATA_W-1:0]     <= wdata_i;
      if (dl_hi_we_i) dl_q[CNT_W-1:DATA_W] <= wdata_i;
    end else if (expired) begin
      if (!warn_q) begin
        warn_q <= 1'b1;
        dl_q   <= deadline(count_i, span_q_i);
      end else begin
        rst_req_q <= 1'b1;
      end
    end
  end

  // R2: a refresh leaves both stages clear
  assert_refresh_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_i |=> !warn_q && !rst_req_q);
  // R5: warning only appears after an expiry and reloads the deadline
  assert_warn_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_q) |-> $past(expired));
  assert_warn_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_q) |-> dl_q == $past(count_i) + {{PAD_W{1'b0}}, $past(span_q_i)});
  // R6: second stage requires the first and holds until refresh
  assert_stage_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |-> warn_q);
  assert_reset_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q && !refresh_i |=> rst_req_q);
  // R7: a disabled watchdog never signals
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |-> !warn_q && !rst_req_q);
  // R11: a direct deadline write suppresses any stage change that cycle
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    direct_wr && !refresh_i |=> $stable(warn_q) && $stable(rst_req_q));
endmodule

// File: rtl/dual_stage_wdog.sv
module dual_stage_wdog
  import dswd_pkg::*;
#(
  parameter logic [DATA_W-1:0] IDENT = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  sys_count,
  input  logic              rf_sel,
  input  logic              rf_wr,
  input  logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_rdata,
  input  logic              cf_sel,
  input  logic              cf_wr,
  input  logic [ADDR_W-1:0] cf_addr,
  input  logic [DATA_W-1:0] cf_wdata,
  output logic [DATA_W-1:0] cf_rdata,
  output logic              warn_o,
  output logic              wdog_reset_o
);
  logic [CNT_W-1:0]  dl;
  logic              warn, rst_req, enable, refresh, dl_lo_we, dl_hi_we, expired;
  logic [SPAN_W-1:0] span_q, span_now;

  dswd_regs #(.IDENT(IDENT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .rf_sel(rf_sel), .rf_wr(rf_wr), .rf_addr(rf_addr), .rf_rdata(rf_rdata),
    .cf_sel(cf_sel), .cf_wr(cf_wr), .cf_addr(cf_addr), .cf_wdata(cf_wdata),
    .cf_rdata(cf_rdata),
    .dl_i(dl), .warn_i(warn), .rst_req_i(rst_req),
    .enable_o(enable), .span_q_o(span_q), .span_now_o(span_now),
    .refresh_o(refresh), .dl_lo_we_o(dl_lo_we), .dl_hi_we_o(dl_hi_we)
  );

  dswd_core u_core (
    .clk(clk), .rst_n(rst_n), .count_i(sys_count),
    .enable_i(enable), .refresh_i(refresh),
    .span_now_i(span_now), .span_q_i(span_q),
    .dl_lo_we_i(dl_lo_we), .dl_hi_we_i(dl_hi_we), .wdata_i(cf_wdata),
    .dl_q(dl), .warn_q(warn), .rst_req_q(rst_req), .expired(expired)
  );

  assign warn_o       = warn;
  assign wdog_reset_o = rst_req;

  // R1: both lines are low in the first cycle out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !warn_o && !wdog_reset_o);
endmodule

// File: tb/dual_stage_wdog_test.sv
module dual_stage_wdog_test;
  localparam logic [31:0] ID = 32'h5A17_0C03;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = 64'd1000;
  logic        rf_sel = 0, rf_wr = 0, cf_sel = 0, cf_wr = 0;
  logic [11:0] rf_addr = 0, cf_addr = 0;
  logic [31:0] cf_wdata = 0;
  logic [31:0] rf_rdata, cf_rdata;
  logic        warn, wrst;

  int    checks = 0, failures = 0, cycles = 0;
  string req = "R1";
  bit    freeze = 0;

  // behavioural reference state
  bit          m_en, m_w0, m_w1;
  logic [31:0] m_span;
  logic [63:0] m_dl;

  dual_stage_wdog #(.IDENT(ID)) uut (
    .clk(clk), .rst_n(rst_n), .sys_count(cnt),
    .rf_sel(rf_sel), .rf_wr(rf_wr), .rf_addr(rf_addr), .rf_rdata(rf_rdata),
    .cf_sel(cf_sel), .cf_wr(cf_wr), .cf_addr(cf_addr), .cf_wdata(cf_wdata),
    .cf_rdata(cf_rdata), .warn_o(warn), .wdog_reset_o(wrst)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++; checks++;
      $display("FAIL %s watchdog expired: cycles=%0d expected<150000", req, cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_cf();
    if (!cf_sel) return 0;
    case (cf_addr)
      12'h000: return {29'd0, m_w1, m_w0, m_en};
      12'h008: return m_span;
      12'h010: return m_dl[31:0];
      12'h014: return m_dl[63:32];
      12'hFCC: return ID;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rf();
    return (rf_sel && rf_addr == 12'hFCC) ? ID : 32'd0;
  endfunction

  // one clock: predict, step, compare on the falling edge
  task automatic step();
    bit kick, wc, ws, wl, wh, exp_hit;
    logic [31:0] sp;
    kick = rf_sel && rf_wr && rf_addr == 12'h000;
    wc = cf_sel && cf_wr && cf_addr == 12'h000;
    ws = cf_sel && cf_wr && cf_addr == 12'h008;
    wl = cf_sel && cf_wr && cf_addr == 12'h010;
    wh = cf_sel && cf_wr && cf_addr == 12'h014;
    exp_hit = m_en && (cnt > m_dl);
    sp = ws ? cf_wdata : m_span;
    @(posedge clk);
    if (kick || wc || ws) begin
      m_w0 = 0; m_w1 = 0; m_dl = cnt + {32'd0, sp};
    end else if (wl || wh) begin
      if (wl) m_dl[31:0] = cf_wdata;
      if (wh) m_dl[63:32] = cf_wdata;
    end else if (exp_hit) begin
      if (m_w0) m_w1 = 1;
      else begin m_w0 = 1; m_dl = cnt + {32'd0, m_span}; end
    end
    if (wc) m_en = cf_wdata[0];
    if (ws) m_span = cf_wdata;
    @(negedge clk);
    check(req, "warn_o", warn, m_w0);
    check(req, "wdog_reset_o", wrst, m_w1);
    check(req, "cf_rdata", cf_rdata, exp_cf());
    check(req, "rf_rdata", rf_rdata, exp_rf());
    if (!freeze) cnt = cnt + 1;
    rf_sel = 0; rf_wr = 0; cf_sel = 0; cf_wr = 0;
  endtask

  task automatic cf_write(logic [11:0] a, logic [31:0] d);
    cf_sel = 1; cf_wr = 1; cf_addr = a; cf_wdata = d; step();
  endtask
  task automatic cf_read(logic [11:0] a);
    cf_sel = 1; cf_wr = 0; cf_addr = a; step();
  endtask
  task automatic kick_at(logic [11:0] a);
    rf_sel = 1; rf_wr = 1; rf_addr = a; step();
  endtask
  task automatic idle(int n, logic [11:0] a);
    for (int i = 0; i < n; i++) cf_read(a);
  endtask

  initial begin
    m_en = 0; m_w0 = 0; m_w1 = 0; m_span = 0; m_dl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    req = "R1";
    cf_read(12'h000); cf_read(12'h008); cf_read(12'h010); cf_read(12'h014);
    check("R1", "warn after reset", warn, 0);
    // R4 deadline halves, no refresh
    req = "R4";
    cf_write(12'h010, 32'h0000_1100); cf_write(12'h014, 32'h0000_0001);
    cf_read(12'h010); cf_read(12'h014);
    cf_write(12'h014, 32'h0); cf_read(12'h014);
    // R3 span and control writes refresh
    req = "R3";
    cf_write(12'h008, 32'd40); cf_read(12'h010);
    cf_write(12'h000, 32'h1); cf_read(12'h000); cf_read(12'h010);
    // R5 first expiry, R6 second expiry and stickiness
    req = "R5"; idle(45, 12'h010);
    check("R5", "warning raised", warn, 1);
    req = "R6"; idle(50, 12'h000);
    check("R6", "reset request raised", wrst, 1);
    kick_at(12'h004); cf_read(12'h000);
    check("R10", "kick at other offset ignored", wrst, 1);
    // R2 kick refresh, R8 status layout
    req = "R2"; kick_at(12'h000);
    req = "R8"; cf_read(12'h000);
    check("R8", "status after kick", cf_rdata, 32'h1);
    // R5 equality boundary with frozen count
    req = "R5"; freeze = 1;
    cf_write(12'h010, cnt[31:0] + 32'd20); cf_write(12'h014, cnt[63:32]);
    cnt = m_dl; idle(4, 12'h000);
    check("R5", "equal count no expiry", warn, 0);
    cnt = m_dl + 1; idle(2, 12'h010);
    check("R5", "one past deadline", warn, 1);
    freeze = 0;
    // R10 reserved offsets and unselected reads
    req = "R10";
    cf_write(12'h00C, 32'hDEAD_BEEF); cf_read(12'h00C); cf_read(12'h008);
    rf_sel = 1; rf_addr = 12'h000; step();
    step();
    // R9 identification
    req = "R9"; cf_read(12'hFCC);
    rf_sel = 1; rf_addr = 12'hFCC; step();
    check("R9", "kick-port ident", rf_rdata, ID);
    // R11 refresh beats direct write; direct write beats expiry
    req = "R11";
    rf_sel = 1; rf_wr = 1; rf_addr = 12'h000;
    cf_sel = 1; cf_wr = 1; cf_addr = 12'h010; cf_wdata = 32'h0; step();
    cf_read(12'h010);
    cf_write(12'h014, 32'h0); cf_write(12'h010, 32'h5);
    check("R11", "no expiry during write", warn, 0);
    cf_write(12'h014, 32'h0);
    check("R11", "still no expiry", warn, 0);
    cf_read(12'h000);
    check("R11", "expiry after writes", warn, 1);
    // R2 wrap of the 64-bit addition
    req = "R2";
    cnt = 64'hFFFF_FFFF_FFFF_FFF0;
    cf_write(12'h008, 32'h40); cf_read(12'h010); cf_read(12'h014);
    idle(8, 12'h010);
    // R7 disabled: no stage asserts
    req = "R7";
    cf_write(12'h000, 32'h0); cf_write(12'h010, 32'h0); cf_write(12'h014, 32'h0);
    cnt = 64'h0000_0100_0000_0000; idle(20, 12'h000);
    check("R7", "disabled warn", warn, 0);
    check("R7", "disabled reset", wrst, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule